// File: doc/BRIEF.md
# I2C Frame FIFO Pair

This block holds two eight-entry queues of 9-bit frames that sit between a register interface and an I2C frame engine. The transmit queue takes frames from the register side and hands them to the engine. The receive queue takes frames from the engine and hands them back to the register side. Each queue has a valid/ready stream on its input and another on its output. Each queue also has its own enable pin and reports a 3-bit fill level, a half flag, a full flag and a sticky overflow flag.

The fill level is only three bits wide, so it reads zero both when a queue is empty and when it holds eight frames. The full flag tells these two cases apart. On the receive side, software uses the full flag as its receive indication.

A soft-reset request empties both queues, but only when the receive queue is already empty. If the receive queue still holds data, the request is refused and a sticky busy-error flag is raised.

Back-pressure works as follows:
- An input stream is ready only while its queue is enabled and not full. A frame is taken on a cycle where valid and ready are both high.
- A frame offered while the queue is enabled and full is dropped, and the overflow flag is set.
- An output stream is valid only while its queue is enabled and not empty. A frame leaves on a cycle where valid and ready are both high.

Top module: `frame_fifo_pair`

## Requirements
- R1: Each queue stores up to 8 frames of 9 bits. Frames leave in the order they entered, with no change to their value.
- R2: The level output equals the number of stored frames modulo 8. With 8 frames stored, the level is 0 and the full flag is 1.
- R3: The half flag is 1 exactly when a queue holds 4 or more frames.
- R4: The full flag is 1 exactly when a queue holds 8 frames. While it is 1, the input ready is 0.
- R5: A frame offered to an enabled, full queue is dropped and the stored frames are unchanged. The queue's overflow flag is set and stays set until a soft reset is accepted.
- R6: While a queue is empty, its output valid is 0 and its output data shows the most recently removed frame (0 after reset). A ready on the empty output changes nothing.
- R7: While a queue's enable is 0, both its ready and valid are 0. Offered frames and pops are ignored, no overflow is flagged, and the stored frames are kept.
- R8: A soft-reset request made while the receive queue is empty is accepted. On the next cycle both queues are empty, and both overflow flags and the busy-error flag are 0.
- R9: A soft-reset request made while the receive queue holds any frame is refused. No frame is removed, and the busy-error flag becomes 1 on the next cycle and stays 1 until a soft reset is accepted.
- R10: After the hardware reset, both queues are empty, all flags are 0 and both output data values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit queue enable |
| rx_en | input | 1 | Receive queue enable |
| soft_rst_req | input | 1 | Soft-reset request, sampled each cycle |
| busy_err | output | 1 | Sticky flag: a soft reset was refused |
| tx_in_valid | input | 1 | Frame offered to transmit queue |
| tx_in_ready | output | 1 | Transmit queue can take a frame |
| tx_in_data | input | 9 | Frame offered to transmit queue |
| tx_out_valid | output | 1 | Transmit queue has a frame for the engine |
| tx_out_ready | input | 1 | Engine takes the transmit frame |
| tx_out_data | output | 9 | Head of transmit queue, or last removed frame |
| tx_level | output | 3 | Transmit fill level modulo 8 |
| tx_half | output | 1 | Transmit queue holds 4 or more frames |
| tx_full | output | 1 | Transmit queue holds 8 frames |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_in_valid | input | 1 | Frame offered by the engine |
| rx_in_ready | output | 1 | Receive queue can take a frame |
| rx_in_data | input | 9 | Frame offered by the engine |
| rx_out_valid | output | 1 | Receive queue has a frame |
| rx_out_ready | input | 1 | Register side takes the receive frame |
| rx_out_data | output | 9 | Head of receive queue, or last removed frame |
| rx_level | output | 3 | Receive fill level modulo 8 |
| rx_half | output | 1 | Receive queue holds 4 or more frames |
| rx_full | output | 1 | Receive queue holds 8 frames (receive indication) |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
Every result that comes from state is due one clock edge after its cause. This covers the level, the half, full and overflow flags, the busy-error flag and the effect of a flush. The bench therefore drives each stimulus at a falling edge and reads these results one time unit after the rising edge that follows. The output data and the valid and ready signals are combinational from stored state. The bench reads them at the falling edge that starts a pop, before the rising edge that removes the frame. Refused and ignored stimuli are checked the same way: the level, the flags and the output data are read back on the cycle right after the stimulus.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  parameter int unsigned DEF_FRAME_W = 9;
  parameter int unsigned DEF_DEPTH   = 8;

  typedef struct packed {
    logic half;
    logic full;
    logic ovf;
  } fifo_flags_t;
endpackage

// File: rtl/fill_decode.sv
module fill_decode #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned HALF_AT = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned LVL_W  = $clog2(DEPTH)
) (
  input  logic [CNT_W-1:0] count,
  output logic [LVL_W-1:0] level,
  output logic             half,
  output logic             full
);
  always_comb begin
    level = count[LVL_W-1:0];
    half  = (count >= CNT_W'(HALF_AT));
    full  = (count == CNT_W'(DEPTH));
  end
endmodule

// File: rtl/frame_fifo.sv
module frame_fifo
  import fifo_pair_pkg::*;
#(
  parameter int unsigned W       = DEF_FRAME_W,
  parameter int unsigned DEPTH   = DEF_DEPTH,
  parameter int unsigned HALF_AT = DEF_DEPTH / 2,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic [PTR_W-1:0] level,
  output fifo_flags_t      flags
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [W-1:0]     last_q;
  logic             ovf_q;
  logic             is_full, is_half, is_empty;
  logic             push_ok, pop_ok, drop;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  fill_decode #(.DEPTH(DEPTH), .HALF_AT(HALF_AT)) u_dec (
    .count (count),
    .level (level),
    .half  (is_half),
    .full  (is_full)
  );

  always_comb begin
    is_empty  = (count == '0);
    in_ready  = en & ~is_full;
    out_valid = en & ~is_empty;
    push_ok   = in_valid & in_ready & ~flush;
    pop_ok    = out_valid & out_ready & ~flush;
    drop      = en & in_valid & is_full & ~flush;
    out_data  = is_empty ? last_q : mem[rd_ptr];
    flags     = '{half: is_half, full: is_full, ovf: ovf_q};
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
      ovf_q  <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok) begin
        rd_ptr <= next_ptr(rd_ptr);
        last_q <= mem[rd_ptr];
      end
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop) ovf_q <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)) else $error("count above depth"); // R1

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_valid && is_full && !out_ready && !flush)
      |=> (count == CNT_W'(DEPTH)) && ovf_q) else $error("full push not dropped"); // R5

  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && is_empty && out_ready && !in_valid && !flush)
      |=> $stable(rd_ptr) && $stable(last_q) && (count == '0)) else $error("empty pop moved state"); // R6

  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flush) |=> $stable(count) && $stable(wr_ptr) && $stable(rd_ptr) && $stable(ovf_q))
    else $error("disabled queue changed"); // R7
endmodule

// File: rtl/srst_guard.sv
module srst_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic rx_holding,
  output logic flush,
  output logic busy_err
);
  always_comb flush = req & ~rx_holding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_err <= 1'b0;
    else if (req && rx_holding) busy_err <= 1'b1;
    else if (flush)            busy_err <= 1'b0;
  end

  AST_REJECT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && rx_holding) |=> busy_err) else $error("refusal not flagged"); // R9
endmodule

// File: rtl/frame_fifo_pair.sv
module frame_fifo_pair
  import fifo_pair_pkg::*;
#(
  parameter int unsigned W      = DEF_FRAME_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned LVL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             soft_rst_req,
  output logic             busy_err,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [W-1:0]     tx_in_data,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [W-1:0]     tx_out_data,
  output logic [LVL_W-1:0] tx_level,
  output logic             tx_half,
  output logic             tx_full,
  output logic             tx_ovf,
  input  logic             rx_in_valid,
  output logic             rx_in_ready,
  input  logic [W-1:0]     rx_in_data,
  output logic             rx_out_valid,
  input  logic             rx_out_ready,
  output logic [W-1:0]     rx_out_data,
  output logic [LVL_W-1:0] rx_level,
  output logic             rx_half,
  output logic             rx_full,
  output logic             rx_ovf
);
  fifo_flags_t tx_flags, rx_flags;
  logic        flush, rx_holding;

  frame_fifo #(.W(W), .DEPTH(DEPTH), .HALF_AT(DEPTH / 2)) u_tx (
    .clk, .rst_n, .en(tx_en), .flush,
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level), .flags(tx_flags)
  );

  frame_fifo #(.W(W), .DEPTH(DEPTH), .HALF_AT(DEPTH / 2)) u_rx (
    .clk, .rst_n, .en(rx_en), .flush,
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .level(rx_level), .flags(rx_flags)
  );

  always_comb begin
    rx_holding = (rx_level != '0) | rx_flags.full;
    tx_half    = tx_flags.half;
    tx_full    = tx_flags.full;
    tx_ovf     = tx_flags.ovf;
    rx_half    = rx_flags.half;
    rx_full    = rx_flags.full;
    rx_ovf     = rx_flags.ovf;
  end

  srst_guard u_guard (
    .clk, .rst_n, .req(soft_rst_req), .rx_holding, .flush, .busy_err
  );

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_level == '0) && !tx_full && (rx_level == '0) && !rx_full && !tx_ovf && !rx_ovf && !busy_err)
    else $error("flush left data"); // R8
endmodule

// File: tb/sim_frame_fifo_pair.sv
module sim_frame_fifo_pair;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic tx_en = 0, rx_en = 0, soft_rst_req = 0, busy_err;
  logic tx_in_valid = 0, tx_in_ready, tx_out_valid, tx_out_ready = 0;
  logic [8:0] tx_in_data = '0, tx_out_data;
  logic [2:0] tx_level;
  logic tx_half, tx_full, tx_ovf;
  logic rx_in_valid = 0, rx_in_ready, rx_out_valid, rx_out_ready = 0;
  logic [8:0] rx_in_data = '0, rx_out_data;
  logic [2:0] rx_level;
  logic rx_half, rx_full, rx_ovf;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_fifo_pair u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input bit rx, input logic [8:0] d);
    @(negedge clk);
    if (rx) begin rx_in_valid = 1; rx_in_data = d; end
    else    begin tx_in_valid = 1; tx_in_data = d; end
    @(posedge clk); #1;
    rx_in_valid = 0; tx_in_valid = 0;
  endtask

  task automatic pop(input bit rx, output logic v, output logic [8:0] d);
    @(negedge clk);
    v = rx ? rx_out_valid : tx_out_valid;
    d = rx ? rx_out_data : tx_out_data;
    if (rx) rx_out_ready = 1; else tx_out_ready = 1;
    @(posedge clk); #1;
    rx_out_ready = 0; tx_out_ready = 0;
  endtask

  task automatic soft_reset();
    @(negedge clk); soft_rst_req = 1;
    @(posedge clk); #1; soft_rst_req = 0;
  endtask

  task automatic t_reset();
    check("R10 tx_level", tx_level, 0);
    check("R10 rx_level", rx_level, 0);
    check("R10 flags", {tx_half, tx_full, tx_ovf, rx_half, rx_full, rx_ovf, busy_err}, 0);
    check("R10 out data", {tx_out_data, rx_out_data}, 0);
    check("R7 ready low when disabled", {tx_in_ready, rx_in_ready, tx_out_valid, rx_out_valid}, 0);
  endtask

  task automatic t_tx_fill();
    logic v; logic [8:0] d;
    for (int i = 0; i < 8; i++) begin
      push(0, 9'h100 + 9'(i));
      if (i == 2) check("R3 half at 3", tx_half, 0);
      if (i == 3) begin check("R3 half at 4", tx_half, 1); check("R2 level 4", tx_level, 4); end
    end
    check("R2 level wraps at 8", tx_level, 0);
    check("R4 full at 8", tx_full, 1);
    check("R4 ready low when full", tx_in_ready, 0);
    push(0, 9'h0AA);
    check("R5 overflow set", tx_ovf, 1);
    check("R5 still full", {tx_full, tx_level}, 4'h8);
    for (int i = 0; i < 8; i++) begin
      pop(0, v, d);
      check("R1 tx order", {v, d}, {1'b1, 9'h100 + 9'(i)});
    end
    check("R6 empty valid low", tx_out_valid, 0);
    check("R6 last value shown", tx_out_data, 9'h107);
    pop(0, v, d);
    check("R6 empty pop no effect", {v, tx_level, tx_full, tx_out_data}, {1'b0, 3'd0, 1'b0, 9'h107});
    check("R5 overflow sticky", tx_ovf, 1);
  endtask

  task automatic t_rx_disable();
    logic v; logic [8:0] d;
    rx_en = 0;
    push(1, 9'h055);
    check("R7 push ignored", {rx_level, rx_ovf}, 0);
    rx_en = 1;
    push(1, 9'h011);
    push(1, 9'h022);
    rx_en = 0;
    pop(1, v, d);
    check("R7 pop ignored", {v, rx_level}, {1'b0, 3'd2});
    rx_en = 1;
  endtask

  task automatic t_srst_reject();
    logic v; logic [8:0] d;
    push(0, 9'h033);
    soft_reset();
    check("R9 busy set", busy_err, 1);
    check("R9 nothing flushed", {rx_level, tx_level, tx_ovf}, {3'd2, 3'd1, 1'b1});
    pop(1, v, d); check("R1 rx first", {v, d}, {1'b1, 9'h011});
    pop(1, v, d); check("R1 rx second", {v, d}, {1'b1, 9'h022});
    check("R9 busy sticky", busy_err, 1);
    soft_reset();
    check("R8 accepted flush", {busy_err, tx_level, tx_full, tx_ovf, rx_level}, 0);
  endtask

  task automatic t_rx_full();
    logic v; logic [8:0] d;
    for (int i = 0; i < 8; i++) push(1, 9'h1F0 + 9'(i));
    check("R4 rx indication", {rx_full, rx_level, rx_half}, {1'b1, 3'd0, 1'b1});
    push(1, 9'h000);
    check("R5 rx overflow", rx_ovf, 1);
    soft_reset();
    check("R9 full rx refuses reset", {busy_err, rx_full}, 2'b11);
    pop(1, v, d);
    check("R1 rx head after drop", {v, d}, {1'b1, 9'h1F0});
    check("R2 level after pop", {rx_full, rx_level, rx_half}, {1'b0, 3'd7, 1'b1});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    tx_en = 1; rx_en = 1;
    t_tx_fill();
    t_rx_disable();
    t_srst_reject();
    t_rx_full();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule